// File: doc/BRIEF.md
# Translation Buffer with Fault Signalling

This block is a small, fully associative address translation buffer. It sits between a processor's load/store port and a cache that uses physical addresses. Each access presents a virtual address, a read/write flag, the program counter of the issuing instruction and a valid strobe. In the same cycle, the block does one of two things. It forwards the physical address to the cache, or it raises exactly one of three exception flags: translation miss, page not present, or write to a read-only page.

Handler software installs page table entries through a refill port. The block stores each refilled entry as it is, without looking at its present bit. The retried access then hits. If the stored entry is not present, that hit turns into a page-not-present exception rather than a second miss. This keeps the frequent miss path cheap.

On any exception the block records two values for the handler: the program counter of the faulting instruction, so it can be restarted, and the faulting virtual page number. Pages are 4 KiB, so the low 12 address bits pass through untranslated.

Top module: `tlb_fault_unit`

## Requirements
- R1: An access whose page number matches a valid entry that is present, and either a read or a write to a writable entry, asserts `mem_req` in the same cycle. `mem_paddr` equals {entry physical page, low 12 bits of `acc_vaddr`}, and `mem_wr` equals `acc_wr`.
- R2: An access whose page number (`acc_vaddr[31:12]`) matches no valid entry asserts `exc_miss` in the same cycle.
- R3: A refill is stored whatever its present bit. A later access to that page hits. If the entry has present = 0, the access raises `exc_pgflt` and not `exc_miss`.
- R4: A write (`acc_wr` = 1) that hits a present entry with writable = 0 raises `exc_wprot`. A read of the same entry translates normally.
- R5: `mem_req` is asserted only with `acc_vld` and never in a cycle with an exception flag.
- R6: At most one exception flag is high at a time. The priority is miss, then not present, then write protection. A write to a non-present read-only page reports only `exc_pgflt`.
- R7: On the clock edge that ends an excepting access, `epc_q` takes `acc_pc`. In all other cycles it holds its value.
- R8: On the clock edge that ends an excepting access, `badvpn_q` takes the access's page number. In all other cycles it holds its value.
- R9: A refill whose page number matches a valid entry overwrites that entry in place and does not advance the replacement pointer.
- R10: A refill of a new page goes to the slot named by a round-robin pointer. The pointer then advances and wraps after 8 slots, so the ninth new page since reset evicts the first.
- R11: `flush` invalidates every entry in one cycle. A refill in the same cycle as `flush` is dropped.
- R12: After reset, no entry is valid, the replacement pointer is at slot 0, and `epc_q` and `badvpn_q` read 0.
- R13: With `acc_vld` low, no exception flag and no `mem_req` is asserted, and the captured registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Invalidate all entries |
| acc_vld | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_vaddr | input | 32 | Virtual address |
| acc_pc | input | 32 | Program counter of the accessing instruction |
| fill_vld | input | 1 | Refill write strobe |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_ppn | input | 20 | Refill physical page number |
| fill_present | input | 1 | Refill present bit |
| fill_writable | input | 1 | Refill write-permission bit |
| mem_req | output | 1 | Cache request strobe |
| mem_wr | output | 1 | Cache request is a write |
| mem_paddr | output | 32 | Physical address |
| exc_miss | output | 1 | Translation miss exception |
| exc_pgflt | output | 1 | Page not present exception |
| exc_wprot | output | 1 | Write protection exception |
| epc_q | output | 32 | Program counter of the last faulting access |
| badvpn_q | output | 20 | Page number of the last faulting access |

## Verification
Some properties can be checked on every cycle: the flags are mutually exclusive, the cache strobe never appears next to an exception or without an access, the page offset passes through, and both capture registers load on an exception and hold otherwise. Other behaviour depends on what is stored, and only the directed scenarios can show it. That covers refill-then-retry turning into a page fault, in-place overwrite, round-robin eviction order, the effect of a flush, and the exact physical page returned.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;
  localparam int VPN_W_DEF   = 20;
  localparam int PPN_W_DEF   = 20;
  localparam int OFF_W_DEF   = 12;
  localparam int PC_W_DEF    = 32;
  localparam int ENTRIES_DEF = 8;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_MISS  = 2'd1,
    EXC_PGFLT = 2'd2,
    EXC_WPROT = 2'd3
  } exc_kind_e;
endpackage

// File: rtl/tlbf_reset_sync.sv
module tlbf_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tlbf_entry_array.sv
module tlbf_entry_array #(
  parameter int ENTRIES = tlbf_pkg::ENTRIES_DEF,
  parameter int VPN_W   = tlbf_pkg::VPN_W_DEF,
  parameter int PPN_W   = tlbf_pkg::PPN_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             fill_vld,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_present,
  input  logic             fill_writable,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_present,
  output logic             lk_writable
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [ENTRIES-1:0] pres_q, wrt_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q, rr_d;

  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] fill_match;
  logic [ENTRIES-1:0] slot_sel;
  logic [ENTRIES-1:0] slot_wen;
  logic               fill_hit;
  logic               fill_go;

  assign fill_go  = fill_vld && !flush;
  assign fill_hit = |fill_match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign hit_vec[g]    = vld_q[g] && (tag_q[g] == lk_vpn);
    assign fill_match[g] = vld_q[g] && (tag_q[g] == fill_vpn);
    assign slot_sel[g]   = fill_hit ? fill_match[g] : (rr_q == IDX_W'(g));
    assign slot_wen[g]   = fill_go && slot_sel[g];

    always_ff @(posedge clk) begin
      if (slot_wen[g]) begin
        tag_q[g]  <= fill_vpn;
        ppn_q[g]  <= fill_ppn;
        pres_q[g] <= fill_present;
        wrt_q[g]  <= fill_writable;
      end
    end
  end

  always_comb begin
    vld_d = vld_q;
    rr_d  = rr_q;
    if (flush) begin
      vld_d = '0;
    end else if (fill_vld) begin
      vld_d = vld_q | slot_sel;
      if (!fill_hit) rr_d = (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

  always_comb begin
    lk_ppn      = '0;
    lk_present  = 1'b0;
    lk_writable = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_ppn      = lk_ppn | ({PPN_W{hit_vec[i]}} & ppn_q[i]);
      lk_present  = lk_present | (hit_vec[i] & pres_q[i]);
      lk_writable = lk_writable | (hit_vec[i] & wrt_q[i]);
    end
  end

  assign lk_hit = |hit_vec;
endmodule

// File: rtl/tlbf_fault_logic.sv
module tlbf_fault_logic
  import tlbf_pkg::*;
(
  input  logic      acc_vld,
  input  logic      acc_wr,
  input  logic      lk_hit,
  input  logic      lk_present,
  input  logic      lk_writable,
  output exc_kind_e kind,
  output logic      grant
);
  always_comb begin
    kind  = EXC_NONE;
    grant = 1'b0;
    if (acc_vld) begin
      if (!lk_hit)                      kind = EXC_MISS;
      else if (!lk_present)             kind = EXC_PGFLT;
      else if (acc_wr && !lk_writable)  kind = EXC_WPROT;
      else                              grant = 1'b1;
    end
  end
endmodule

// File: rtl/tlbf_capture.sv
module tlbf_capture #(
  parameter int PC_W  = tlbf_pkg::PC_W_DEF,
  parameter int VPN_W = tlbf_pkg::VPN_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [PC_W-1:0]  pc_in,
  input  logic [VPN_W-1:0] vpn_in,
  output logic [PC_W-1:0]  epc_q,
  output logic [VPN_W-1:0] bad_q
);
  logic [PC_W-1:0]  epc_d;
  logic [VPN_W-1:0] bad_d;

  always_comb begin
    epc_d = epc_q;
    bad_d = bad_q;
    if (cap_en) begin
      epc_d = pc_in;
      bad_d = vpn_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q <= '0;
      bad_q <= '0;
    end else begin
      epc_q <= epc_d;
      bad_q <= bad_d;
    end
  end
endmodule

// File: rtl/tlb_fault_unit.sv
module tlb_fault_unit
  import tlbf_pkg::*;
#(
  parameter int ENTRIES = ENTRIES_DEF,
  parameter int VPN_W   = VPN_W_DEF,
  parameter int PPN_W   = PPN_W_DEF,
  parameter int OFF_W   = OFF_W_DEF,
  parameter int PC_W    = PC_W_DEF,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             acc_vld,
  input  logic             acc_wr,
  input  logic [VA_W-1:0]  acc_vaddr,
  input  logic [PC_W-1:0]  acc_pc,
  input  logic             fill_vld,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_present,
  input  logic             fill_writable,
  output logic             mem_req,
  output logic             mem_wr,
  output logic [PA_W-1:0]  mem_paddr,
  output logic             exc_miss,
  output logic             exc_pgflt,
  output logic             exc_wprot,
  output logic [PC_W-1:0]  epc_q,
  output logic [VPN_W-1:0] badvpn_q
);
  logic             rst_sync_n;
  logic [VPN_W-1:0] acc_vpn;
  logic [OFF_W-1:0] acc_off;
  logic             lk_hit, lk_present, lk_writable;
  logic [PPN_W-1:0] lk_ppn;
  exc_kind_e        kind;
  logic             grant;
  logic             any_exc;

  assign acc_vpn = acc_vaddr[VA_W-1:OFF_W];
  assign acc_off = acc_vaddr[OFF_W-1:0];

  tlbf_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tlbf_entry_array #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W)
  ) u_array (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .flush         (flush),
    .lk_vpn        (acc_vpn),
    .fill_vld      (fill_vld),
    .fill_vpn      (fill_vpn),
    .fill_ppn      (fill_ppn),
    .fill_present  (fill_present),
    .fill_writable (fill_writable),
    .lk_hit        (lk_hit),
    .lk_ppn        (lk_ppn),
    .lk_present    (lk_present),
    .lk_writable   (lk_writable)
  );

  tlbf_fault_logic u_fault (
    .acc_vld     (acc_vld),
    .acc_wr      (acc_wr),
    .lk_hit      (lk_hit),
    .lk_present  (lk_present),
    .lk_writable (lk_writable),
    .kind        (kind),
    .grant       (grant)
  );

  assign exc_miss  = (kind == EXC_MISS);
  assign exc_pgflt = (kind == EXC_PGFLT);
  assign exc_wprot = (kind == EXC_WPROT);
  assign any_exc   = (kind != EXC_NONE);

  assign mem_req   = grant;
  assign mem_wr    = grant & acc_wr;
  assign mem_paddr = grant ? {lk_ppn, acc_off} : '0;

  tlbf_capture #(
    .PC_W  (PC_W),
    .VPN_W (VPN_W)
  ) u_cap (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cap_en (any_exc),
    .pc_in  (acc_pc),
    .vpn_in (acc_vpn),
    .epc_q  (epc_q),
    .bad_q  (badvpn_q)
  );
endmodule

// File: rtl/tlbf_checker.sv
module tlbf_checker #(
  parameter int VPN_W = 20,
  parameter int OFF_W = 12,
  parameter int PC_W  = 32,
  parameter int PPN_W = 20
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic                   flush,
  input logic                   acc_vld,
  input logic                   acc_wr,
  input logic [VPN_W+OFF_W-1:0] acc_vaddr,
  input logic [PC_W-1:0]        acc_pc,
  input logic                   mem_req,
  input logic                   mem_wr,
  input logic [PPN_W+OFF_W-1:0] mem_paddr,
  input logic                   exc_miss,
  input logic                   exc_pgflt,
  input logic                   exc_wprot,
  input logic [PC_W-1:0]        epc_q,
  input logic [VPN_W-1:0]       badvpn_q
);
  logic any_exc;
  assign any_exc = exc_miss | exc_pgflt | exc_wprot;

  AST_ONE_EXC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({exc_miss, exc_pgflt, exc_wprot})); // R6
  AST_REQ_NO_EXC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req |-> (acc_vld && !any_exc)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_vld |-> (!any_exc && !mem_req)); // R13
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req |-> (mem_paddr[OFF_W-1:0] == acc_vaddr[OFF_W-1:0])); // R1
  AST_WR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req |-> (mem_wr == acc_wr)); // R1
  AST_EPC_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    any_exc |=> (epc_q == $past(acc_pc))); // R7
  AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !any_exc |=> $stable(epc_q)); // R7
  AST_BAD_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    any_exc |=> (badvpn_q == $past(acc_vaddr[VPN_W+OFF_W-1:OFF_W]))); // R8
  AST_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !any_exc |=> $stable(badvpn_q)); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush |=> (!acc_vld || exc_miss)); // R11
endmodule

bind tlb_fault_unit tlbf_checker #(
  .VPN_W (VPN_W),
  .OFF_W (OFF_W),
  .PC_W  (PC_W),
  .PPN_W (PPN_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .flush      (flush),
  .acc_vld    (acc_vld),
  .acc_wr     (acc_wr),
  .acc_vaddr  (acc_vaddr),
  .acc_pc     (acc_pc),
  .mem_req    (mem_req),
  .mem_wr     (mem_wr),
  .mem_paddr  (mem_paddr),
  .exc_miss   (exc_miss),
  .exc_pgflt  (exc_pgflt),
  .exc_wprot  (exc_wprot),
  .epc_q      (epc_q),
  .badvpn_q   (badvpn_q)
);

// File: tb/tlb_fault_unit_tb.sv
module tlb_fault_unit_tb_top;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int OFF_W = 12;
  localparam int PC_W  = 32;

  logic             clk;
  logic             rst_n;
  logic             flush;
  logic             acc_vld;
  logic             acc_wr;
  logic [31:0]      acc_vaddr;
  logic [PC_W-1:0]  acc_pc;
  logic             fill_vld;
  logic [VPN_W-1:0] fill_vpn;
  logic [PPN_W-1:0] fill_ppn;
  logic             fill_present;
  logic             fill_writable;
  logic             mem_req, mem_wr;
  logic [31:0]      mem_paddr;
  logic             exc_miss, exc_pgflt, exc_wprot;
  logic [PC_W-1:0]  epc_q;
  logic [VPN_W-1:0] badvpn_q;

  int n_chk;
  int n_bad;
  bit done;

  logic        r_req, r_wr, r_miss, r_pf, r_wp;
  logic [31:0] r_pa;
  logic [31:0] r_epc;
  logic [19:0] r_bad;

  tlb_fault_unit dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_vaddr(acc_vaddr), .acc_pc(acc_pc),
    .fill_vld(fill_vld), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_present(fill_present), .fill_writable(fill_writable),
    .mem_req(mem_req), .mem_wr(mem_wr), .mem_paddr(mem_paddr),
    .exc_miss(exc_miss), .exc_pgflt(exc_pgflt), .exc_wprot(exc_wprot),
    .epc_q(epc_q), .badvpn_q(badvpn_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; flush = 1'b0; acc_vld = 1'b0; acc_wr = 1'b0;
    acc_vaddr = '0; acc_pc = '0; fill_vld = 1'b0; fill_vpn = '0;
    fill_ppn = '0; fill_present = 1'b0; fill_writable = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [19:0] ppn,
                         input logic pres, input logic wrt);
    @(negedge clk);
    fill_vld = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
    fill_present = pres; fill_writable = wrt;
    @(posedge clk); #1;
    fill_vld = 1'b0;
  endtask

  task automatic do_access(input logic [19:0] vpn, input logic [11:0] off,
                           input logic wr, input logic [31:0] pc);
    @(negedge clk);
    acc_vld = 1'b1; acc_wr = wr; acc_vaddr = {vpn, off}; acc_pc = pc;
    #2;
    r_req = mem_req; r_wr = mem_wr; r_pa = mem_paddr;
    r_miss = exc_miss; r_pf = exc_pgflt; r_wp = exc_wprot;
    @(posedge clk); #1;
    acc_vld = 1'b0;
    #2;
    r_epc = epc_q; r_bad = badvpn_q;
  endtask

  task automatic t_reset();
    apply_reset();
    #2;
    chk("R12 epc after reset", epc_q, 0);
    chk("R12 badvpn after reset", badvpn_q, 0);
    chk("R13 idle no req", {mem_req, exc_miss, exc_pgflt, exc_wprot}, 0);
    do_access(20'h00000, 12'h000, 1'b0, 32'h0);
    chk("R12 empty after reset -> miss", {r_miss, r_pf, r_wp, r_req}, 4'b1000);
    do_access(20'h12345, 12'h678, 1'b0, 32'h0000_1000);
    chk("R2 miss flag", r_miss, 1);
    chk("R5 no req on miss", r_req, 0);
    chk("R7 epc captured", r_epc, 32'h0000_1000);
    chk("R8 badvpn captured", r_bad, 20'h12345);
  endtask

  task automatic t_hit();
    do_fill(20'h00A10, 20'hBEE01, 1'b1, 1'b1);
    do_fill(20'h00A11, 20'hBEE02, 1'b1, 1'b0);
    do_access(20'h00A10, 12'hABC, 1'b0, 32'h0000_2000);
    chk("R1 read hit req", {r_req, r_miss, r_pf, r_wp}, 4'b1000);
    chk("R1 read hit paddr", r_pa, 32'hBEE01ABC);
    chk("R1 read mem_wr", r_wr, 0);
    chk("R7 epc held on hit", r_epc, 32'h0000_1000);
    do_access(20'h00A10, 12'h004, 1'b1, 32'h0000_2004);
    chk("R1 write hit paddr", r_pa, 32'hBEE01004);
    chk("R1 write mem_wr", r_wr, 1);
    do_access(20'h00A11, 12'hFFF, 1'b0, 32'h0000_2008);
    chk("R4 read of read-only page hits", {r_req, r_pa}, {1'b1, 32'hBEE02FFF});
    chk("R8 badvpn held on hit", r_bad, 20'h12345);
  endtask

  task automatic t_pgflt();
    do_fill(20'h00B00, 20'h00777, 1'b0, 1'b1);
    do_access(20'h00B00, 12'h010, 1'b0, 32'h0000_3000);
    chk("R3 not-present hit -> pgflt only", {r_miss, r_pf, r_wp}, 3'b010);
    chk("R5 no req on pgflt", r_req, 0);
    chk("R7 epc on pgflt", r_epc, 32'h0000_3000);
    chk("R8 badvpn on pgflt", r_bad, 20'h00B00);
  endtask

  task automatic t_wprot();
    do_access(20'h00A11, 12'h020, 1'b1, 32'h0000_4000);
    chk("R4 write to read-only -> wprot", {r_miss, r_pf, r_wp}, 3'b001);
    chk("R5 no req on wprot", r_req, 0);
    chk("R7 epc on wprot", r_epc, 32'h0000_4000);
  endtask

  task automatic t_priority();
    do_fill(20'h00C00, 20'h00888, 1'b0, 1'b0);
    do_access(20'h00C00, 12'h0, 1'b1, 32'h0000_5000);
    chk("R6 not-present read-only write -> pgflt only", {r_miss, r_pf, r_wp}, 3'b010);
    do_access(20'h0FFFF, 12'h0, 1'b1, 32'h0000_5004);
    chk("R6 write miss -> miss only", {r_miss, r_pf, r_wp}, 3'b100);
  endtask

  task automatic t_idle();
    do_fill(20'h00D00, 20'h00999, 1'b1, 1'b1);
    @(negedge clk);
    acc_vld = 1'b0; acc_wr = 1'b1; acc_vaddr = 32'hFEDC_B000; acc_pc = 32'hDEAD_0000;
    #2;
    chk("R13 idle no flags", {mem_req, exc_miss, exc_pgflt, exc_wprot}, 0);
    @(posedge clk); #3;
    chk("R13 idle epc unchanged", epc_q, 32'h0000_5004);
    chk("R13 idle badvpn unchanged", badvpn_q, 20'h0FFFF);
  endtask

  task automatic t_replace();
    apply_reset();
    do_fill(20'h00100, 20'h00001, 1'b1, 1'b1);
    do_fill(20'h00101, 20'h00002, 1'b1, 1'b1);
    do_fill(20'h00100, 20'h000AA, 1'b1, 1'b1);
    do_access(20'h00100, 12'h0, 1'b0, 32'h0);
    chk("R9 overwrite gives new ppn", r_pa, 32'h000AA000);
    for (int i = 0; i < 6; i++)
      do_fill(20'h00200 + 20'(i), 20'h00300 + 20'(i), 1'b1, 1'b1);
    do_fill(20'h00400, 20'h00444, 1'b1, 1'b1);
    do_access(20'h00100, 12'h0, 1'b0, 32'h0000_6000);
    chk("R10 first slot evicted on wrap", r_miss, 1);
    do_access(20'h00101, 12'h0, 1'b0, 32'h0);
    chk("R9 overwrite did not advance pointer", {r_req, r_pa}, {1'b1, 32'h00002000});
    do_access(20'h00400, 12'h123, 1'b0, 32'h0);
    chk("R10 newest installed", r_pa, 32'h00444123);
    do_access(20'h00205, 12'h0, 1'b0, 32'h0);
    chk("R10 last slot still held", r_pa, 32'h00305000);
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
    do_access(20'h00101, 12'h0, 1'b0, 32'h0000_7000);
    chk("R11 flushed entry misses", {r_miss, r_req}, 2'b10);
    do_access(20'h00400, 12'h0, 1'b0, 32'h0000_7004);
    chk("R11 all entries flushed", r_miss, 1);
    @(negedge clk);
    flush = 1'b1; fill_vld = 1'b1; fill_vpn = 20'h00500; fill_ppn = 20'h00555;
    fill_present = 1'b1; fill_writable = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0; fill_vld = 1'b0;
    do_access(20'h00500, 12'h0, 1'b0, 32'h0000_7008);
    chk("R11 fill with flush dropped", r_miss, 1);
    do_fill(20'h00500, 20'h00555, 1'b1, 1'b1);
    do_access(20'h00500, 12'h001, 1'b0, 32'h0);
    chk("R3 refill then retry hits", r_pa, 32'h00555001);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    t_reset();
    t_hit();
    t_pgflt();
    t_wprot();
    t_priority();
    t_idle();
    t_replace();
    t_flush();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule